// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is a timer/counter that produces center-aligned PWM. The counter rises one step on each enabled tick from zero to an upper limit, stays at that limit for one tick, then falls back to zero and starts again. Because both slopes are used, a full period takes twice the limit in ticks. Each compare channel turns its output off on the rising slope and back on on the falling slope. The resulting pulse therefore sits symmetrically around the bottom of the count.

The upper limit comes from a mode input. It can be one of three fixed limits (8, 9 or 10 bits), a period register, or the compare value of channel 0. Software writes the compare and period values into buffer registers at any time. The buffered values become active only at the turning point at the top of the count, so a period never mixes old and new settings. Sticky flags mark the bottom of the count, each compare match and the top in period mode. A clear strobe drops a flag.

Top module: `pwm_dual_slope`

## Requirements
- R1: On each tick the count moves by exactly one. It rises from 0 to TOP, holds TOP for one tick, falls to 0, holds 0 for one tick and rises again, so one period is 2*TOP ticks. If TOP drops below the current count while rising, the count turns and falls.
- R2: `mode_i` selects TOP. 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the active period register and 4 gives the active compare value of channel 0. Codes 5 to 7 act like code 0.
- R3: A TOP taken from a register is never below 3. A register value of 0, 1 or 2 gives TOP = 3.
- R4: The count, the outputs and the flags change only on clock edges where `tick_i` is high.
- R5: With `inv_i[c]` = 0, a tick at count = compare value clears the output of channel c on the rising slope (TOP included) and sets it on the falling slope (0 included). For 0 < C < TOP the output is high for 2*C ticks of each period.
- R6: With `inv_i[c]` = 1, the output of channel c is the complement of the R5 level.
- R7: A non-inverted channel with compare value 0 stays high for the whole period. One with a compare value at or above TOP stays low for the whole period, with no pulse.
- R8: A tick at count 0 sets `ovf_flag_o`. The flag stays set until `ovf_clr_i` clears it.
- R9: A tick at count equal to the active compare value of channel c sets `cmp_flag_o[c]`. The flag stays set until `cmp_clr_i[c]` clears it.
- R10: In mode 3, the tick taken at TOP sets `top_flag_o`. The flag stays set until `top_clr_i` clears it.
- R11: A written compare or period value stays in its buffer. It becomes active only on the tick taken at TOP, and the turn at that tick still uses the old TOP.
- R12: Reset (`rst_ni` low) clears the count, buffers, active values, output levels and flags, and sets the direction to rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | count enable (prescaled tick) |
| mode_i | input | 3 | TOP source select |
| inv_i | input | CH_N | per-channel output inversion |
| period_wr_i | input | 1 | period buffer write strobe |
| period_data_i | input | W | period write data |
| cmp_wr_i | input | CH_N | per-channel compare buffer write strobe |
| cmp_data_i | input | W | compare write data |
| ovf_clr_i | input | 1 | clear bottom flag |
| top_clr_i | input | 1 | clear top flag |
| cmp_clr_i | input | CH_N | clear compare flags |
| count_o | output | W | current count |
| pwm_o | output | CH_N | PWM outputs |
| ovf_flag_o | output | 1 | bottom flag |
| top_flag_o | output | 1 | top flag (period mode) |
| cmp_flag_o | output | CH_N | compare match flags |

## Verification
The bench runs a table of configurations. Each one is measured over a full period, recording the highest count seen and the number of ticks each output is high.

- **TOP source:** the configurations cover every mode code, including a reserved one. A reserved code that picked up the wrong limit shows up as a wrong peak count.
- **Clamping:** register values of 1 and 3 separate correct clamping from an off-by-one at the minimum.
- **Duty and level:** mid-range compare values check the 2*C duty law. Compare values of 0, exactly TOP and above TOP separate the steady-level cases from a one-tick glitch. Inverted channels sit next to non-inverted ones.
- **Buffering and flags:** directed steps follow the count around two turning points. They show that a new period takes effect only after the turn at the old TOP. They also check that the flags set and clear on the expected ticks.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;
  typedef enum logic [2:0] {
    TOP_FIX8   = 3'd0,
    TOP_FIX9   = 3'd1,
    TOP_FIX10  = 3'd2,
    TOP_PERIOD = 3'd3,
    TOP_CMP0   = 3'd4
  } top_sel_e;

  localparam int unsigned MIN_TOP = 3;
endpackage

// File: rtl/pwm_top_sel.sv
module pwm_top_sel #(
  parameter int unsigned W = 16
) (
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] cmp0_i,
  output logic [W-1:0] top_o
);
  import pwm_ds_pkg::*;

  localparam logic [W-1:0] FIX8  = W'(16'h00FF);
  localparam logic [W-1:0] FIX9  = W'(16'h01FF);
  localparam logic [W-1:0] FIX10 = W'(16'h03FF);
  localparam logic [W-1:0] VMIN  = W'(MIN_TOP);

  logic [W-1:0] var_top;
  logic         use_var;

  always_comb begin
    var_top = period_i;
    use_var = 1'b0;
    top_o   = FIX8;
    case (top_sel_e'(mode_i))
      TOP_FIX9:   top_o = FIX9;
      TOP_FIX10:  top_o = FIX10;
      TOP_PERIOD: begin var_top = period_i; use_var = 1'b1; end
      TOP_CMP0:   begin var_top = cmp0_i;   use_var = 1'b1; end
      default:    top_o = FIX8;
    endcase
    if (use_var) top_o = (var_top < VMIN) ? VMIN : var_top;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] count_o,
  output logic         up_o,
  output logic         at_top_o,
  output logic         rising_o
);
  logic [W-1:0] cnt_q;
  logic         up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_i) begin
      if (up_q && cnt_q >= top_i) begin
        cnt_q <= cnt_q - 1'b1;
        up_q  <= 1'b0;
      end else if (up_q) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (cnt_q == '0) begin
        cnt_q <= cnt_q + 1'b1;
        up_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign count_o  = cnt_q;
  assign up_o     = up_q;
  // >= so a TOP lowered below the count still turns it
  assign at_top_o = up_q && (cnt_q >= top_i);
  assign rising_o = up_q && (cnt_q != '0);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         load_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] top_i,
  input  logic         rising_i,
  input  logic         at_top_i,
  input  logic         inv_i,
  input  logic         clr_i,
  output logic [W-1:0] cmp_act_o,
  output logic         pwm_o,
  output logic         flag_o
);
  logic [W-1:0] buf_q, act_q;
  logic         lvl_q, flag_q;
  logic         match, clr_evt, set_evt;

  assign match   = (count_i == act_q);
  // compare at/above TOP: force low at the top so no pulse escapes
  assign clr_evt = tick_i && rising_i && (match || (at_top_i && act_q >= top_i));
  assign set_evt = tick_i && !rising_i && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      act_q  <= '0;
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i) buf_q <= data_i;
      if (load_i) act_q <= buf_q;
      if (clr_evt)      lvl_q <= 1'b0;
      else if (set_evt) lvl_q <= 1'b1;
      if (tick_i && match) flag_q <= 1'b1;
      else if (clr_i)      flag_q <= 1'b0;
    end
  end

  assign cmp_act_o = act_q;
  assign pwm_o     = lvl_q ^ inv_i;
  assign flag_o    = flag_q;
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope #(
  parameter int unsigned W    = 16,
  parameter int unsigned CH_N = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [2:0]      mode_i,
  input  logic [CH_N-1:0] inv_i,
  input  logic            period_wr_i,
  input  logic [W-1:0]    period_data_i,
  input  logic [CH_N-1:0] cmp_wr_i,
  input  logic [W-1:0]    cmp_data_i,
  input  logic            ovf_clr_i,
  input  logic            top_clr_i,
  input  logic [CH_N-1:0] cmp_clr_i,
  output logic [W-1:0]    count_o,
  output logic [CH_N-1:0] pwm_o,
  output logic            ovf_flag_o,
  output logic            top_flag_o,
  output logic [CH_N-1:0] cmp_flag_o
);
  import pwm_ds_pkg::*;

  logic [W-1:0]            cnt, top_val, per_buf_q, per_act_q;
  logic                    up, at_top, rising, load;
  logic [CH_N-1:0][W-1:0]  cmp_act;
  logic                    ovf_q, topf_q;

  pwm_top_sel #(.W(W)) u_sel (
    .mode_i   (mode_i),
    .period_i (per_act_q),
    .cmp0_i   (cmp_act[0]),
    .top_o    (top_val)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .top_i    (top_val),
    .count_o  (cnt),
    .up_o     (up),
    .at_top_o (at_top),
    .rising_o (rising)
  );

  assign load = tick_i && at_top;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    pwm_channel #(.W(W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .wr_i      (cmp_wr_i[c]),
      .data_i    (cmp_data_i),
      .load_i    (load),
      .count_i   (cnt),
      .top_i     (top_val),
      .rising_i  (rising),
      .at_top_i  (at_top),
      .inv_i     (inv_i[c]),
      .clr_i     (cmp_clr_i[c]),
      .cmp_act_o (cmp_act[c]),
      .pwm_o     (pwm_o[c]),
      .flag_o    (cmp_flag_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_buf_q <= '0;
      per_act_q <= '0;
      ovf_q     <= 1'b0;
      topf_q    <= 1'b0;
    end else begin
      if (period_wr_i) per_buf_q <= period_data_i;
      if (load)        per_act_q <= per_buf_q;
      if (tick_i && cnt == '0) ovf_q <= 1'b1;
      else if (ovf_clr_i)      ovf_q <= 1'b0;
      if (load && top_sel_e'(mode_i) == TOP_PERIOD) topf_q <= 1'b1;
      else if (top_clr_i)                           topf_q <= 1'b0;
    end
  end

  assign count_o    = cnt;
  assign ovf_flag_o = ovf_q;
  assign top_flag_o = topf_q;
endmodule

// File: rtl/pwm_dual_slope_chk.sv
module pwm_dual_slope_chk #(
  parameter int unsigned W    = 16,
  parameter int unsigned CH_N = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   tick_i,
  input logic [CH_N-1:0]        inv_i,
  input logic [W-1:0]           count_o,
  input logic [CH_N-1:0]        pwm_o,
  input logic                   ovf_flag_o,
  input logic [CH_N-1:0]        cmp_flag_o,
  input logic                   up,
  input logic [W-1:0]           top_val,
  input logic [CH_N-1:0][W-1:0] cmp_act
);
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (count_o == $past(count_o) + 1'b1) || (count_o == $past(count_o) - 1'b1));

  p_turn_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && up && count_o >= top_val) |=> (count_o == $past(count_o) - 1'b1));

  p_bottom_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o == '0) |=> (count_o == W'(1)));

  p_min_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_val >= W'(3));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

  p_pwm_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && $stable(inv_i)) |=> $stable(pwm_o));

  p_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o == '0) |=> ovf_flag_o);

  for (genvar c = 0; c < CH_N; c++) begin : g_a
    p_cmp_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && count_o == cmp_act[c]) |=> cmp_flag_o[c]);
  end
endmodule

bind pwm_dual_slope pwm_dual_slope_chk #(.W(W), .CH_N(CH_N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .inv_i      (inv_i),
  .count_o    (count_o),
  .pwm_o      (pwm_o),
  .ovf_flag_o (ovf_flag_o),
  .cmp_flag_o (cmp_flag_o),
  .up         (up),
  .top_val    (top_val),
  .cmp_act    (cmp_act)
);

// File: tb/pwm_dual_slope_test.sv
`timescale 1ns/1ps
module pwm_dual_slope_test;
  localparam int W = 16;
  localparam int CH_N = 2;

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] per;
    logic [15:0] c0;
    logic [15:0] c1;
    logic        i0;
    logic        i1;
    logic [15:0] top;
    logic [15:0] h0;
    logic [15:0] h1;
  } vec_t;

  // expected high ticks: C==0 -> 2T, C>=T -> 0, else 2C; inverted -> 2T minus that
  localparam vec_t VECS [8] = '{
    '{3'd0, 16'd0,  16'd100, 16'd0,    1'b0, 1'b0, 16'd255,  16'd200,  16'd510},
    '{3'd1, 16'd0,  16'd511, 16'd300,  1'b0, 1'b1, 16'd511,  16'd0,    16'd422},
    '{3'd2, 16'd0,  16'd1,   16'd2000, 1'b1, 1'b0, 16'd1023, 16'd2044, 16'd0},
    '{3'd3, 16'd40, 16'd10,  16'd39,   1'b0, 1'b0, 16'd40,   16'd20,   16'd78},
    '{3'd3, 16'd3,  16'd1,   16'd2,    1'b0, 1'b0, 16'd3,    16'd2,    16'd4},
    '{3'd3, 16'd1,  16'd2,   16'd3,    1'b0, 1'b0, 16'd3,    16'd4,    16'd0},
    '{3'd4, 16'd0,  16'd60,  16'd25,   1'b0, 1'b1, 16'd60,   16'd0,    16'd70},
    '{3'd7, 16'd0,  16'd255, 16'd254,  1'b0, 1'b0, 16'd255,  16'd0,    16'd508}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic [2:0]      mode = 3'd0;
  logic [CH_N-1:0] inv = '0;
  logic            per_wr = 1'b0;
  logic [W-1:0]    per_data = '0;
  logic [CH_N-1:0] cmp_wr = '0;
  logic [W-1:0]    cmp_data = '0;
  logic            ovf_clr = 1'b0, top_clr = 1'b0;
  logic [CH_N-1:0] cmp_clr = '0;
  logic [W-1:0]    count;
  logic [CH_N-1:0] pwm;
  logic            ovf_flag, top_flag;
  logic [CH_N-1:0] cmp_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dual_slope #(.W(W), .CH_N(CH_N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_i(mode), .inv_i(inv),
    .period_wr_i(per_wr), .period_data_i(per_data),
    .cmp_wr_i(cmp_wr), .cmp_data_i(cmp_data),
    .ovf_clr_i(ovf_clr), .top_clr_i(top_clr), .cmp_clr_i(cmp_clr),
    .count_o(count), .pwm_o(pwm), .ovf_flag_o(ovf_flag),
    .top_flag_o(top_flag), .cmp_flag_o(cmp_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_per(input int v);
    per_data = W'(v); per_wr = 1'b1;
    @(negedge clk);
    per_wr = 1'b0;
  endtask

  task automatic wr_cmp(input int ch, input int v);
    cmp_data = W'(v); cmp_wr = '0; cmp_wr[ch] = 1'b1;
    @(negedge clk);
    cmp_wr = '0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12 count at reset", int'(count), 0);
    chk("R12 pwm at reset", int'(pwm), 0);
    chk("R12 flags at reset", int'({ovf_flag, top_flag, cmp_flag}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R2 R3 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      int hi0, hi1, mx;
      mode = VECS[v].mode;
      inv  = {VECS[v].i1, VECS[v].i0};
      wr_per(int'(VECS[v].per));
      wr_cmp(0, int'(VECS[v].c0));
      wr_cmp(1, int'(VECS[v].c1));
      ticks(4200);
      hi0 = 0; hi1 = 0; mx = 0;
      tick = 1'b1;
      for (int i = 0; i < 2 * int'(VECS[v].top); i++) begin
        @(negedge clk);
        if (pwm[0]) hi0++;
        if (pwm[1]) hi1++;
        if (int'(count) > mx) mx = int'(count);
      end
      tick = 1'b0;
      chk($sformatf("R2 R3 vec%0d peak", v), mx, int'(VECS[v].top));
      chk($sformatf("R5 R6 R7 vec%0d ch0 high ticks", v), hi0, int'(VECS[v].h0));
      chk($sformatf("R5 R6 R7 vec%0d ch1 high ticks", v), hi1, int'(VECS[v].h1));
    end

    // directed: R1 R4 R8 R9 R10 R11
    inv = '0;
    mode = 3'd3;
    do_reset();
    wr_per(20);
    wr_cmp(1, 5);
    ticks(1);
    chk("R1 first step", int'(count), 1);
    chk("R8 bottom flag", int'(ovf_flag), 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R8 bottom flag clear", int'(ovf_flag), 0);
    ticks(2);
    chk("R3 clamped top reached", int'(count), 3);
    chk("R10 top flag before top tick", int'(top_flag), 0);
    ticks(1);
    chk("R11 turn at old top", int'(count), 2);
    chk("R10 top flag set", int'(top_flag), 1);
    repeat (5) @(negedge clk);
    chk("R4 held without tick", int'(count), 2);
    wr_per(8);
    ticks(22);
    chk("R11 new period active", int'(count), 20);
    chk("R9 compare flag ch1", int'(cmp_flag[1]), 1);
    ticks(1);
    chk("R1 turn at top", int'(count), 19);
    ticks(27);
    chk("R11 second buffered period", int'(count), 8);
    ticks(1);
    chk("R1 turn at new top", int'(count), 7);
    cmp_clr = '1; top_clr = 1'b1;
    @(negedge clk);
    cmp_clr = '0; top_clr = 1'b0;
    chk("R9 compare flag clear", int'(cmp_flag), 0);
    chk("R10 top flag clear", int'(top_flag), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule